// File: doc/BRIEF.md
# NAND Page Register and Storage Array

This block models the storage side of a small NAND flash device: an array of pages, each holding a data area and a spare area, together with the page register that collects program data. A command sequencer outside the block decodes the command stream and raises single-cycle strobes. These strobes clear and fill the page register, commit it into a page, erase a whole erase block, load a read pointer and step through a page one byte at a time.

Programming can only clear bits, because the register is ANDed into the stored bytes. Erase returns a whole block, spare included, to 0xFF. Both operations are gated by an unlock input, take a bounded number of cycles and hold `busy` high while they run. After reset the block erases the entire array, so every byte reads 0xFF once `busy` falls. A read covers the page data plus spare, or the data area only when `spare_off` is high. When a read runs off the end of its page it continues seamlessly into the next page.

Top module: `nand_pagearray`

## Requirements
- R1: After reset `dout` is 0x00 and `busy` is high for exactly ARR_BYTES cycles (pages × page image size) while every byte is set to 0xFF. Afterwards every byte reads 0xFF.
- R2: The spare area holds PAGE_BYTES/32 bytes, so a page image is PAGE_BYTES + PAGE_BYTES/32 bytes (66 by default). A read loaded at column 0 with `spare_off` low returns all of it.
- R3: `prog_setup` empties the page register. Each `din_we` appends `din`, but only until a full page image is held; further bytes are dropped.
- R4: `prog_go` with `unlock` high ANDs the register bytes into page `row`, starting at byte `col + col_ofs`, and stops at the end of the page image. It writes one byte per cycle, and `busy` stays high for exactly the number of bytes written.
- R5: With `unlock` low, `prog_go` and `erase_go` are ignored: `busy` stays low and the array is unchanged.
- R6: `erase_go` sets every byte of the erase block that contains `row` (block = row / PAGES_PER_BLK, spare included) to 0xFF, with `busy` high for exactly one block's bytes. Other blocks are untouched. When `erase_go` and `prog_go` arrive together, the erase runs and the program is dropped.
- R7: A `prog_go`, `erase_go` or `rd_load` whose `row` is NUM_PAGES or more is ignored.
- R8: `rd_load` sets the start column to `col + col_ofs` and the remaining length to limit − start. The limit is the page image size, or PAGE_BYTES when `spare_off` is high at the load. A start at or beyond the limit gives length zero.
- R9: Each `rd_next` with length remaining places the byte at the pointer on `dout` one cycle later and advances the pointer by one byte.
- R10: `rd_next` with zero length remaining moves to column 0 of the next page, wrapping from the last page to page 0. It returns that byte, and the new length is limit − 1, using `spare_off` as it is at that strobe.
- R11: While `busy` is high, all strobes are ignored (`prog_setup`, `din_we`, `prog_go`, `erase_go`, `rd_load`, `rd_next`) and `dout` holds.
- R12: When `din_we` and `rd_next` fall in the same idle cycle, both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prog_setup | input | 1 | Empty the page register |
| din_we | input | 1 | Append `din` to the page register |
| din | input | 8 | Program data byte |
| prog_go | input | 1 | Commit the page register into page `row` |
| erase_go | input | 1 | Erase the block containing `row` |
| rd_load | input | 1 | Load the read pointer from `row`, `col`, `col_ofs` |
| rd_next | input | 1 | Return the next read byte on `dout` |
| row | input | ROW_W | Page index (one extra bit so out-of-range rows can be presented) |
| col | input | COL_W | Column within the page image |
| col_ofs | input | COL_W | Column offset added to `col` |
| unlock | input | 1 | High allows program and erase |
| spare_off | input | 1 | High limits reads to the data area |
| dout | output | 8 | Last byte read |
| busy | output | 1 | Commit or erase in progress |

## Verification
Two functions of this block can fall in the same cycle. The first pair is filling the page register and streaming a read. The bench raises `din_we` and `rd_next` together for several cycles, checks each streamed byte against its model, and then commits the register to show that every byte was also captured. The second pair is an erase and a program strobed together: the bench requires the erase-length busy window and a page of 0xFF. A further case strobes reads and appends during a commit's busy window. It judges them ignored by a held `dout`, by a pointer that resumes where it stopped, and by a later commit of unchanged length.

// File: rtl/nand_pa_pkg.sv
// Shared types and helpers for the NAND page array.
// Assumes page sizes that are multiples of 32 bytes.
package nand_pa_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PROG  = 2'd1,
        ST_ERASE = 2'd2
    } op_st_e;

    // Spare bytes per page: one thirty-second of the data area.
    function automatic int spare_bytes(input int page_bytes);
        return page_bytes / 32;
    endfunction

endpackage

// File: rtl/nand_pa_buf.sv
// Page register: collects program bytes in arrival order up to DEPTH bytes.
// Assumes the caller gates clr/push with the busy state; rd_idx < len.
module nand_pa_buf #(
    parameter int DEPTH = 66,
    parameter int LEN_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic [7:0]       din,
    input  logic [LEN_W-1:0] rd_idx,
    output logic [LEN_W-1:0] len,
    output logic [7:0]       rd_data
);

    logic [7:0] store [DEPTH];
    logic       room;

    assign room    = (len < LEN_W'(DEPTH));
    assign rd_data = store[rd_idx];

    // Fill level: cleared by setup, grows by one per accepted byte.
    always_ff @(posedge clk) begin
        if (!rst_n)            len <= '0;
        else if (clr)          len <= '0;
        else if (push && room) len <= len + 1'b1;
    end

    // Byte storage: write the incoming byte at the fill level.
    always_ff @(posedge clk) begin
        if (!clr && push && room) store[len] <= din;
    end

    assert_len_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        len <= LEN_W'(DEPTH));

    assert_full_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (len == LEN_W'(DEPTH) && !clr) |=> len == LEN_W'(DEPTH));

endmodule

// File: rtl/nand_pa_mem.sv
// Byte array holding all page images; one write port that can AND or
// overwrite, one asynchronous read port. No reset: the controller erases
// the whole array after reset.
module nand_pa_mem #(
    parameter int BYTES  = 2112,
    parameter int ADDR_W = $clog2(BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              and_en,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rdata
);

    logic [7:0] cells [BYTES];

    assign rdata = cells[raddr];

    // Write port: AND merge for program, plain store for erase.
    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= and_en ? (cells[waddr] & wdata) : wdata;
    end

    assert_waddr_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> waddr < ADDR_W'(BYTES));

endmodule

// File: rtl/nand_pa_ctl.sv
// Operation control: sequences commit and erase one byte per cycle and
// drives busy; owns the read pointer and the registered read byte.
// Assumes strobes are single-cycle and row/col are valid with them.
module nand_pa_ctl
    import nand_pa_pkg::*;
#(
    parameter int PAGE_BYTES    = 64,
    parameter int PAGE_TOT      = 66,
    parameter int PAGES_PER_BLK = 8,
    parameter int NUM_PAGES     = 32,
    parameter int ROW_W         = 6,
    parameter int COL_W         = 7,
    parameter int ADDR_W        = 12,
    parameter int CNT_W         = 12,
    parameter int ARR_BYTES     = 2112
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_go,
    input  logic              erase_go,
    input  logic              rd_load,
    input  logic              rd_next,
    input  logic              unlock,
    input  logic              spare_off,
    input  logic [ROW_W-1:0]  row,
    input  logic [COL_W-1:0]  col,
    input  logic [COL_W-1:0]  col_ofs,
    input  logic [COL_W-1:0]  buf_len,
    input  logic [7:0]        buf_data,
    output logic [COL_W-1:0]  buf_idx,
    output logic              mem_we,
    output logic              mem_and,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [7:0]        mem_wdata,
    output logic [ADDR_W-1:0] mem_raddr,
    input  logic [7:0]        mem_rdata,
    output logic [7:0]        dout,
    output logic              busy
);

    localparam int RI_W      = ROW_W - 1;
    localparam int BLK_BYTES = PAGES_PER_BLK * PAGE_TOT;

    op_st_e            state;
    logic [ADDR_W-1:0] wr_ptr;
    logic [CNT_W-1:0]  cnt;
    logic [COL_W-1:0]  bidx;
    logic [RI_W-1:0]   rd_row;
    logic [COL_W-1:0]  rd_col;
    logic [COL_W-1:0]  rd_left;

    logic              row_ok;
    logic [RI_W-1:0]   row_idx;
    logic [COL_W:0]    start_w;
    logic [COL_W:0]    limit_w;
    logic [COL_W:0]    room_w;
    logic [COL_W-1:0]  prog_n;
    logic [RI_W-1:0]   next_row;
    logic [ADDR_W-1:0] blk_base;

    // First byte address of a page image.
    function automatic logic [ADDR_W-1:0] pbase(input logic [RI_W-1:0] r);
        return ADDR_W'(r) * ADDR_W'(PAGE_TOT);
    endfunction

    assign busy     = (state != ST_IDLE);
    assign row_ok   = (row < ROW_W'(NUM_PAGES));
    assign row_idx  = row[RI_W-1:0];
    assign start_w  = {1'b0, col} + {1'b0, col_ofs};
    assign limit_w  = spare_off ? (COL_W+1)'(PAGE_BYTES) : (COL_W+1)'(PAGE_TOT);
    assign room_w   = (COL_W+1)'(PAGE_TOT) - start_w;
    assign next_row = (rd_row == RI_W'(NUM_PAGES - 1)) ? '0 : rd_row + 1'b1;
    assign blk_base = ADDR_W'(row / ROW_W'(PAGES_PER_BLK)) * ADDR_W'(BLK_BYTES);

    // Commit length: register fill, clipped at the end of the page image.
    always_comb begin
        prog_n = '0;
        if (start_w < (COL_W+1)'(PAGE_TOT)) begin
            if ({1'b0, buf_len} < room_w) prog_n = buf_len;
            else                          prog_n = room_w[COL_W-1:0];
        end
    end

    // Write engine: start, step and finish program/erase sequences.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_ERASE;
            wr_ptr <= '0;
            cnt    <= CNT_W'(ARR_BYTES);
            bidx   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (erase_go && unlock && row_ok) begin
                        state  <= ST_ERASE;
                        wr_ptr <= blk_base;
                        cnt    <= CNT_W'(BLK_BYTES);
                    end else if (prog_go && unlock && row_ok && prog_n != '0) begin
                        state  <= ST_PROG;
                        wr_ptr <= pbase(row_idx) + ADDR_W'(start_w);
                        cnt    <= CNT_W'(prog_n);
                        bidx   <= '0;
                    end
                end
                default: begin
                    wr_ptr <= wr_ptr + 1'b1;
                    bidx   <= bidx + 1'b1;
                    cnt    <= cnt - 1'b1;
                    if (cnt == CNT_W'(1)) state <= ST_IDLE;
                end
            endcase
        end
    end

    assign mem_we    = busy;
    assign mem_and   = (state == ST_PROG);
    assign mem_waddr = wr_ptr;
    assign mem_wdata = (state == ST_PROG) ? buf_data : 8'hFF;
    assign buf_idx   = bidx;
    assign mem_raddr = (rd_left != '0) ? pbase(rd_row) + ADDR_W'(rd_col)
                                       : pbase(next_row);

    // Read engine: load pointer, step through page, roll into next page.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_row  <= '0;
            rd_col  <= '0;
            rd_left <= '0;
            dout    <= '0;
        end else if (!busy) begin
            if (rd_load) begin
                if (row_ok) begin
                    rd_row  <= row_idx;
                    rd_col  <= COL_W'(start_w);
                    rd_left <= (limit_w > start_w) ? COL_W'(limit_w - start_w) : '0;
                end
            end else if (rd_next) begin
                dout <= mem_rdata;
                if (rd_left != '0) begin
                    rd_col  <= rd_col + 1'b1;
                    rd_left <= rd_left - 1'b1;
                end else begin
                    rd_row  <= next_row;
                    rd_col  <= COL_W'(1);
                    rd_left <= COL_W'(limit_w - 1'b1);
                end
            end
        end
    end

    assert_locked_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !unlock) |=> !busy);

    assert_bad_row_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !row_ok) |=> !busy);

    assert_rd_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && rd_next && !rd_load && rd_left != '0) |=> rd_left == $past(rd_left) - 1'b1);

    assert_hold_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(dout));

    assert_busy_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cnt != '0 && cnt <= CNT_W'(ARR_BYTES)));

endmodule

// File: rtl/nand_pagearray.sv
// Top of the NAND page array: page register, byte array and operation
// control. Assumes one-cycle strobes from an external command sequencer.
module nand_pagearray #(
    parameter int PAGE_BYTES    = 64,
    parameter int PAGES_PER_BLK = 8,
    parameter int NUM_BLKS      = 4,
    localparam int SPARE        = nand_pa_pkg::spare_bytes(PAGE_BYTES),
    localparam int PAGE_TOT     = PAGE_BYTES + SPARE,
    localparam int NUM_PAGES    = PAGES_PER_BLK * NUM_BLKS,
    localparam int ARR_BYTES    = NUM_PAGES * PAGE_TOT,
    localparam int COL_W        = $clog2(PAGE_TOT + 1),
    localparam int ROW_W        = $clog2(NUM_PAGES) + 1,
    localparam int ADDR_W       = $clog2(ARR_BYTES),
    localparam int CNT_W        = $clog2(ARR_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             prog_setup,
    input  logic             din_we,
    input  logic [7:0]       din,
    input  logic             prog_go,
    input  logic             erase_go,
    input  logic             rd_load,
    input  logic             rd_next,
    input  logic [ROW_W-1:0] row,
    input  logic [COL_W-1:0] col,
    input  logic [COL_W-1:0] col_ofs,
    input  logic             unlock,
    input  logic             spare_off,
    output logic [7:0]       dout,
    output logic             busy
);

    logic [COL_W-1:0]  buf_len;
    logic [COL_W-1:0]  buf_idx;
    logic [7:0]        buf_data;
    logic              mem_we;
    logic              mem_and;
    logic [ADDR_W-1:0] mem_waddr;
    logic [7:0]        mem_wdata;
    logic [ADDR_W-1:0] mem_raddr;
    logic [7:0]        mem_rdata;

    nand_pa_buf #(.DEPTH(PAGE_TOT), .LEN_W(COL_W)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (prog_setup & ~busy),
        .push    (din_we & ~busy),
        .din     (din),
        .rd_idx  (buf_idx),
        .len     (buf_len),
        .rd_data (buf_data)
    );

    nand_pa_mem #(.BYTES(ARR_BYTES), .ADDR_W(ADDR_W)) u_mem (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (mem_we),
        .and_en (mem_and),
        .waddr  (mem_waddr),
        .wdata  (mem_wdata),
        .raddr  (mem_raddr),
        .rdata  (mem_rdata)
    );

    nand_pa_ctl #(
        .PAGE_BYTES    (PAGE_BYTES),
        .PAGE_TOT      (PAGE_TOT),
        .PAGES_PER_BLK (PAGES_PER_BLK),
        .NUM_PAGES     (NUM_PAGES),
        .ROW_W         (ROW_W),
        .COL_W         (COL_W),
        .ADDR_W        (ADDR_W),
        .CNT_W         (CNT_W),
        .ARR_BYTES     (ARR_BYTES)
    ) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .prog_go   (prog_go),
        .erase_go  (erase_go),
        .rd_load   (rd_load),
        .rd_next   (rd_next),
        .unlock    (unlock),
        .spare_off (spare_off),
        .row       (row),
        .col       (col),
        .col_ofs   (col_ofs),
        .buf_len   (buf_len),
        .buf_data  (buf_data),
        .buf_idx   (buf_idx),
        .mem_we    (mem_we),
        .mem_and   (mem_and),
        .mem_waddr (mem_waddr),
        .mem_wdata (mem_wdata),
        .mem_raddr (mem_raddr),
        .mem_rdata (mem_rdata),
        .dout      (dout),
        .busy      (busy)
    );

endmodule

// File: tb/nand_pagearray_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks keep a byte model of the array and push
// expected read bytes; a monitor pops them as the design returns bytes.
module nand_pagearray_tb_top;

    localparam int PB  = 64;
    localparam int PT  = 66;
    localparam int PPB = 8;
    localparam int NP  = 32;
    localparam int BB  = PPB * PT;
    localparam int AB  = NP * PT;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       prog_setup = 1'b0, din_we = 1'b0, prog_go = 1'b0, erase_go = 1'b0;
    logic       rd_load = 1'b0, rd_next = 1'b0, unlock = 1'b1, spare_off = 1'b0;
    logic [7:0] din = 8'h00;
    logic [5:0] row = '0;
    logic [6:0] col = '0, col_ofs = '0;
    logic [7:0] dout;
    logic       busy;

    int vectors = 0, miscompares = 0;
    bit done = 1'b0;
    string cur_tag = "R1";

    logic [7:0] ref_mem [AB];
    logic [7:0] mbuf [PT];
    int mlen = 0;
    int mrow = 0, mcol = 0, mleft = 0;
    logic [7:0] mdout = 8'h00;
    logic [7:0] exp_q [$];
    string tag_q [$];

    always #2.5 clk = ~clk;

    nand_pagearray dut_i (
        .clk(clk), .rst_n(rst_n), .prog_setup(prog_setup), .din_we(din_we),
        .din(din), .prog_go(prog_go), .erase_go(erase_go), .rd_load(rd_load),
        .rd_next(rd_next), .row(row), .col(col), .col_ofs(col_ofs),
        .unlock(unlock), .spare_off(spare_off), .dout(dout), .busy(busy)
    );

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: compare each returned byte with the scoreboard head.
    always @(posedge clk) begin
        if (rd_next) begin
            #1;
            if (exp_q.size() == 0) chk("R9 scoreboard empty", 1, 0);
            else chk(tag_q.pop_front(), dout, exp_q.pop_front());
        end
    end

    task automatic wait_idle(output int n);
        n = 0;
        while (busy) begin n++; @(negedge clk); end
    endtask

    task automatic setup();
        prog_setup = 1'b1; @(negedge clk); prog_setup = 1'b0; mlen = 0;
    endtask

    task automatic push(input logic [7:0] b);
        din_we = 1'b1; din = b; @(negedge clk); din_we = 1'b0;
        if (mlen < PT) begin mbuf[mlen] = b; mlen++; end
    endtask

    task automatic commit(input int r, input int c, input int o, input int exp_busy);
        int n;
        row = 6'(r); col = 7'(c); col_ofs = 7'(o); prog_go = 1'b1;
        @(negedge clk); prog_go = 1'b0;
        if (unlock && r < NP) begin
            for (int i = 0; i < mlen && c + o + i < PT; i++)
                ref_mem[r*PT + c + o + i] &= mbuf[i];
        end
        wait_idle(n);
        chk({cur_tag, " busy cycles"}, n, exp_busy);
    endtask

    task automatic erase(input int r, input int exp_busy);
        int n;
        row = 6'(r); erase_go = 1'b1;
        @(negedge clk); erase_go = 1'b0;
        if (unlock && r < NP)
            for (int i = 0; i < BB; i++) ref_mem[(r/PPB)*BB + i] = 8'hFF;
        wait_idle(n);
        chk({cur_tag, " busy cycles"}, n, exp_busy);
    endtask

    task automatic load(input int r, input int c, input int o);
        int lim;
        row = 6'(r); col = 7'(c); col_ofs = 7'(o); rd_load = 1'b1;
        @(negedge clk); rd_load = 1'b0;
        lim = spare_off ? PB : PT;
        if (r < NP) begin
            mrow = r; mcol = c + o;
            mleft = (lim > c + o) ? lim - (c + o) : 0;
        end
    endtask

    // Model one read strobe and queue its expected byte.
    function automatic void model_step(input bit ign);
        logic [7:0] e;
        int lim;
        lim = spare_off ? PB : PT;
        if (ign) e = mdout;
        else if (mleft != 0) begin
            e = ref_mem[mrow*PT + mcol]; mcol++; mleft--;
        end else begin
            mrow = (mrow + 1) % NP; e = ref_mem[mrow*PT];
            mcol = 1; mleft = lim - 1;
        end
        mdout = e;
        exp_q.push_back(e); tag_q.push_back(cur_tag);
    endfunction

    task automatic rd(input int n);
        for (int i = 0; i < n; i++) begin
            rd_next = 1'b1; model_step(1'b0);
            @(negedge clk); rd_next = 1'b0;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        int n;
        for (int i = 0; i < AB; i++) ref_mem[i] = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state and whole-array init window.
        chk("R1 busy after reset", busy, 1);
        chk("R1 dout after reset", dout, 0);
        wait_idle(n);
        chk("R1 init busy cycles", n, AB);

        cur_tag = "R2 full page read";
        load(0, 0, 0); rd(PT);

        cur_tag = "R4 program and";
        setup();
        for (int i = 0; i < 10; i++) push(8'(8'h3C ^ (i * 17)));
        commit(3, 5, 3, 10);
        load(3, 0, 0); rd(PT);
        setup();
        for (int i = 0; i < 12; i++) push(8'(8'hF0 ^ (i * 5)));
        commit(3, 4, 0, 12);
        load(3, 4, 2); rd(14);

        cur_tag = "R4 clip at page end";
        setup();
        for (int i = 0; i < 70; i++) push(8'(i * 7 + 1));
        commit(9, 60, 0, 6);
        load(9, 58, 0); rd(8);

        cur_tag = "R3 register cap";
        setup();
        for (int i = 0; i < 70; i++) push(8'(~(i * 3)));
        commit(10, 0, 0, PT);
        load(10, 0, 0); rd(PT);

        cur_tag = "R5 locked";
        unlock = 1'b0;
        setup(); for (int i = 0; i < 3; i++) push(8'h00);
        commit(10, 0, 0, 0);
        erase(10, 0);
        unlock = 1'b1;
        load(10, 0, 0); rd(4);

        cur_tag = "R7 out of range";
        commit(40, 0, 0, 0);
        erase(33, 0);
        load(45, 0, 0); rd(2);

        cur_tag = "R8 spare off";
        spare_off = 1'b1;
        load(10, 60, 0); rd(4);
        cur_tag = "R10 roll to next page";
        rd(2);
        spare_off = 1'b0;
        cur_tag = "R8 zero length";
        load(9, 40, 40); rd(2);
        cur_tag = "R10 wrap last page";
        load(31, 65, 0); rd(2);

        cur_tag = "R6 erase block";
        erase(13, BB);
        load(10, 0, 0); rd(8);
        load(3, 6, 0); rd(10);
        cur_tag = "R6 erase beats program";
        setup(); push(8'h00); push(8'h00);
        row = 6'd3; erase_go = 1'b1; prog_go = 1'b1;
        @(negedge clk); erase_go = 1'b0; prog_go = 1'b0;
        for (int i = 0; i < BB; i++) ref_mem[i] = 8'hFF;
        wait_idle(n);
        chk("R6 busy cycles", n, BB);
        load(3, 0, 0); rd(12);

        cur_tag = "R11 busy ignores";
        load(9, 60, 0);
        setup();
        for (int i = 0; i < 4; i++) push(8'(8'h81 + i));
        row = 6'd20; col = '0; col_ofs = '0; prog_go = 1'b1;
        @(negedge clk); prog_go = 1'b0;
        for (int i = 0; i < 4; i++) ref_mem[20*PT + i] &= mbuf[i];
        chk("R11 busy during commit", busy, 1);
        rd_next = 1'b1; model_step(1'b1); din_we = 1'b1; din = 8'h00;
        @(negedge clk); rd_next = 1'b0; din_we = 1'b0;
        rd_load = 1'b1; row = 6'd0;
        @(negedge clk); rd_load = 1'b0;
        wait_idle(n);
        rd(3);
        commit(21, 0, 0, 4);
        load(21, 0, 0); rd(5);

        cur_tag = "R12 append with read";
        load(20, 0, 0);
        setup();
        for (int i = 0; i < 4; i++) begin
            din_we = 1'b1; din = 8'(8'h5A + i * 9); rd_next = 1'b1;
            mbuf[mlen] = din; mlen++;
            model_step(1'b0);
            @(negedge clk); din_we = 1'b0; rd_next = 1'b0;
        end
        commit(22, 0, 0, 4);
        load(22, 0, 0); rd(5);

        repeat (3) @(negedge clk);
        chk("R9 scoreboard drained", exp_q.size(), 0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule